// File: doc/BRIEF.md
# CAN Receiver Flag and Status Register

This block holds the receiver-side flag and status byte of a CAN controller, together with its interrupt enable register. Four sticky flags record hardware events: wake-up, status change, receive overrun and receive buffer full. Each flag has a condition input. While that input is high the flag is set, and a software clear of that flag has no effect. Two 2-bit status fields, one for the receiver and one for the transmitter, follow their hardware inputs and cannot be written.

Software clears a flag by writing a 1 to its bit position. Writing a 0 leaves the flag unchanged. While the controller is in initialization mode (request and acknowledge both high), the four flags are held at zero and all flag writes are dropped. The status fields keep tracking their inputs in that mode. One interrupt output is raised whenever any flag is set and its enable bit is also set.

Top module: `rxflag_reg`

## Requirements
- R1: The read word places its fields at fixed bit positions: bit 7 is wake-up, bit 6 is status change, bits 5:4 are the receiver status, bits 3:2 are the transmitter status, bit 1 is overrun and bit 0 is receive full. `flag_evt` bits 3, 2, 1 and 0 drive wake-up, status change, overrun and receive full, in that order.
- R2: Outside initialization mode, a high condition input sets its flag at the next clock edge, and the flag then stays set.
- R3: When writes are permitted and a flag's condition input is low, writing 1 to that flag's bit clears it at the next edge. Writing 0 to the bit leaves the flag unchanged.
- R4: A clearing write is ignored while the flag's condition input is high, so the flag reads 1 after the write.
- R5: Each status field shows its input value from the previous clock edge. Writes to bits 5:2 have no effect on those bits.
- R6: While `init_req` and `init_ack` are both 1, all four flags read 0 from the next edge onward, and condition inputs have no effect.
- R7: The status fields keep tracking their inputs during initialization mode.
- R8: Flag writes are accepted only when `init_req` and `init_ack` are both 0. If exactly one of them is 1, writes are ignored but condition inputs still set flags.
- R9: The 4-bit enable register uses the same bit order as `flag_evt`, can be written at any time, and reads back what was written.
- R10: `irq` is 1 exactly when at least one flag is set and its enable bit is 1.
- R11: Synchronous reset clears every flag, both status fields and the enable register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_req | input | 1 | Initialization mode request |
| init_ack | input | 1 | Initialization mode acknowledge |
| flag_evt | input | 4 | Flag condition inputs: 3 wake-up, 2 status change, 1 overrun, 0 receive full |
| rx_lvl | input | 2 | Receiver status level input |
| tx_lvl | input | 2 | Transmitter status level input |
| flag_we | input | 1 | Write strobe for the flag register |
| flag_wdata | input | 8 | Flag write data; a 1 clears the flag at that bit position |
| ien_we | input | 1 | Write strobe for the enable register |
| ien_wdata | input | 4 | Enable write data |
| flag_rdata | output | 8 | Flag and status read word |
| ien_rdata | output | 4 | Enable register contents |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume that the condition inputs, the status levels and the initialization handshake are sampled only at the rising clock edge. They also assume that any cycle in which `init_req` and `init_ack` differ belongs to an entry into or an exit from initialization mode. The stimulus changes every input on the falling edge and moves through the handshake one signal at a time: request, then acknowledge, and the reverse on exit. Condition inputs are applied both while a flag is being cleared and while no write is active, so that set-over-clear priority is tested in every mode.

// File: rtl/rxflag_pkg.sv
package rxflag_pkg;

    localparam int NFLAG = 4;
    localparam int STW   = 2;
    localparam int REGW  = 2 * NFLAG;

    // Bit position in the read/write word of each flag, indexed like flag_evt
    localparam int FLAG_BIT [NFLAG] = '{0, 1, 6, 7};

    typedef enum logic [1:0] {
        MODE_RUN   = 2'd0,
        MODE_SHIFT = 2'd1,
        MODE_INIT  = 2'd2
    } mode_t;

    typedef struct packed {
        logic [STW-1:0] rx;
        logic [STW-1:0] tx;
    } stat_t;

    typedef struct packed {
        logic           wake;
        logic           stchg;
        logic [STW-1:0] rx;
        logic [STW-1:0] tx;
        logic           ovr;
        logic           rxf;
    } rdword_t;

    function automatic mode_t decode_mode(input logic req, input logic ack);
        if (req && ack)
            return MODE_INIT;
        else if (req || ack)
            return MODE_SHIFT;
        else
            return MODE_RUN;
    endfunction

    function automatic rdword_t pack_word(input logic [NFLAG-1:0] fl, input stat_t st);
        rdword_t w;
        w.wake  = fl[3];
        w.stchg = fl[2];
        w.rx    = st.rx;
        w.tx    = st.tx;
        w.ovr   = fl[1];
        w.rxf   = fl[0];
        return w;
    endfunction

endpackage

// File: rtl/rxflag_cell.sv
module rxflag_cell (
    input  logic clk,
    input  logic rst,
    input  logic hold_clr,
    input  logic wr_ok,
    input  logic clr_bit,
    input  logic cond,
    output logic q
);
    // Priority: reset / init hold, then set condition, then software clear
    always_ff @(posedge clk) begin
        if (rst || hold_clr)
            q <= 1'b0;
        else if (cond)
            q <= 1'b1;
        else if (wr_ok && clr_bit)
            q <= 1'b0;
    end
endmodule

// File: rtl/rxflag_status.sv
module rxflag_status
    import rxflag_pkg::*;
#(
    parameter int W = STW
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] rx_in,
    input  logic [W-1:0] tx_in,
    output logic [W-1:0] rx_q,
    output logic [W-1:0] tx_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rx_q <= '0;
            tx_q <= '0;
        end else begin
            rx_q <= rx_in;
            tx_q <= tx_in;
        end
    end
endmodule

// File: rtl/rxflag_intc.sv
module rxflag_intc #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en_we,
    input  logic [N-1:0] en_wdata,
    input  logic [N-1:0] flags,
    output logic [N-1:0] en_q,
    output logic         irq
);
    always_ff @(posedge clk) begin
        if (rst)
            en_q <= '0;
        else if (en_we)
            en_q <= en_wdata;
    end

    assign irq = |(flags & en_q);
endmodule

// File: rtl/rxflag_reg.sv
module rxflag_reg
    import rxflag_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             init_req,
    input  logic             init_ack,
    input  logic [NFLAG-1:0] flag_evt,
    input  logic [STW-1:0]   rx_lvl,
    input  logic [STW-1:0]   tx_lvl,
    input  logic             flag_we,
    input  logic [REGW-1:0]  flag_wdata,
    input  logic             ien_we,
    input  logic [NFLAG-1:0] ien_wdata,
    output logic [REGW-1:0]  flag_rdata,
    output logic [NFLAG-1:0] ien_rdata,
    output logic             irq
);
    mode_t            mode;
    logic             hold_clr;
    logic             wr_ok;
    logic [NFLAG-1:0] flags;
    stat_t            st;

    assign mode     = decode_mode(init_req, init_ack);
    assign hold_clr = (mode == MODE_INIT);
    assign wr_ok    = flag_we && (mode == MODE_RUN);

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        rxflag_cell u_cell (
            .clk      (clk),
            .rst      (rst),
            .hold_clr (hold_clr),
            .wr_ok    (wr_ok),
            .clr_bit  (flag_wdata[FLAG_BIT[i]]),
            .cond     (flag_evt[i]),
            .q        (flags[i])
        );
    end

    rxflag_status #(.W(STW)) u_status (
        .clk   (clk),
        .rst   (rst),
        .rx_in (rx_lvl),
        .tx_in (tx_lvl),
        .rx_q  (st.rx),
        .tx_q  (st.tx)
    );

    rxflag_intc #(.N(NFLAG)) u_intc (
        .clk      (clk),
        .rst      (rst),
        .en_we    (ien_we),
        .en_wdata (ien_wdata),
        .flags    (flags),
        .en_q     (ien_rdata),
        .irq      (irq)
    );

    assign flag_rdata = pack_word(flags, st);
endmodule

// File: rtl/rxflag_reg_chk.sv
module rxflag_reg_chk (
    input logic       clk,
    input logic       rst,
    input logic       init_req,
    input logic       init_ack,
    input logic [3:0] flag_evt,
    input logic [1:0] rx_lvl,
    input logic [1:0] tx_lvl,
    input logic       flag_we,
    input logic [7:0] flag_wdata,
    input logic [7:0] flag_rdata,
    input logic [3:0] ien_rdata,
    input logic       irq
);
    // R2
    wake_set_chk: assert property (@(posedge clk) disable iff (rst)
        (!(init_req && init_ack) && flag_evt[3]) |=> flag_rdata[7]);

    // R2
    rxf_set_chk: assert property (@(posedge clk) disable iff (rst)
        (!(init_req && init_ack) && flag_evt[0]) |=> flag_rdata[0]);

    // R3
    rxf_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_we && flag_wdata[0] && !flag_evt[0] && !init_req && !init_ack) |=> !flag_rdata[0]);

    // R4
    ovr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_rdata[1] && flag_evt[1] && !(init_req && init_ack)) |=> flag_rdata[1]);

    // R5
    status_track_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (flag_rdata[5:4] == $past(rx_lvl)) && (flag_rdata[3:2] == $past(tx_lvl)));

    // R6
    init_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (init_req && init_ack) |=> ({flag_rdata[7:6], flag_rdata[1:0]} == 4'b0000));

    // R8
    shift_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
        ((init_req != init_ack) && (flag_evt == 4'b0000)) |=>
        ({flag_rdata[7:6], flag_rdata[1:0]} == $past({flag_rdata[7:6], flag_rdata[1:0]})));

    // R10
    irq_src_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> ((ien_rdata & {flag_rdata[7:6], flag_rdata[1:0]}) != 4'b0000));
endmodule

bind rxflag_reg rxflag_reg_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .init_req   (init_req),
    .init_ack   (init_ack),
    .flag_evt   (flag_evt),
    .rx_lvl     (rx_lvl),
    .tx_lvl     (tx_lvl),
    .flag_we    (flag_we),
    .flag_wdata (flag_wdata),
    .flag_rdata (flag_rdata),
    .ien_rdata  (ien_rdata),
    .irq        (irq)
);

// File: tb/rxflag_reg_tb.sv
module rxflag_reg_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       init_req = 1'b0, init_ack = 1'b0;
    logic [3:0] flag_evt = '0;
    logic [1:0] rx_lvl = '0, tx_lvl = '0;
    logic       flag_we = 1'b0;
    logic [7:0] flag_wdata = '0;
    logic       ien_we = 1'b0;
    logic [3:0] ien_wdata = '0;
    logic [7:0] flag_rdata;
    logic [3:0] ien_rdata;
    logic       irq;

    int checks = 0;
    int errors = 0;
    string tag = "R11";

    // Reference model state
    bit [3:0] m_fl;
    bit [1:0] m_rx, m_tx;
    bit [3:0] m_en;

    always #4 clk = ~clk;

    rxflag_reg u_dut (
        .clk(clk), .rst(rst), .init_req(init_req), .init_ack(init_ack),
        .flag_evt(flag_evt), .rx_lvl(rx_lvl), .tx_lvl(tx_lvl),
        .flag_we(flag_we), .flag_wdata(flag_wdata),
        .ien_we(ien_we), .ien_wdata(ien_wdata),
        .flag_rdata(flag_rdata), .ien_rdata(ien_rdata), .irq(irq)
    );

    function automatic int wbit(int i);
        case (i)
            0: return 0;
            1: return 1;
            2: return 6;
            default: return 7;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_fl = '0; m_rx = '0; m_tx = '0; m_en = '0;
        end else begin
            for (int i = 0; i < 4; i++) begin
                if (init_req && init_ack)                                 m_fl[i] = 1'b0;
                else if (flag_evt[i])                                     m_fl[i] = 1'b1;
                else if (flag_we && !init_req && !init_ack && flag_wdata[wbit(i)]) m_fl[i] = 1'b0;
            end
            m_rx = rx_lvl;
            m_tx = tx_lvl;
            if (ien_we) m_en = ien_wdata;
        end
    end

    task automatic check(string t, logic [31:0] act, logic [31:0] exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", t, what, act, exp);
        end
    endtask

    // Wait to falling edge and compare all outputs against the model
    task automatic tick();
        @(negedge clk);
        check(tag, flag_rdata, {m_fl[3], m_fl[2], m_rx, m_tx, m_fl[1], m_fl[0]}, "flag_rdata");
        check(tag, ien_rdata, m_en, "ien_rdata");
        check(tag, irq, |(m_fl & m_en), "irq");
    endtask

    task automatic idle();
        flag_evt = '0; flag_we = 0; flag_wdata = '0; ien_we = 0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R11: reset state
        tag = "R11";
        repeat (3) tick();
        check("R11", flag_rdata, 8'h00, "reset word");
        rst = 0;
        tick();

        // R2 / R1: each condition sets its own bit
        tag = "R2";
        for (int i = 0; i < 4; i++) begin
            flag_evt = 4'(1 << i); tick();
            idle(); tick();
            check("R1", flag_rdata[wbit(i)], 1'b1, "flag position");
        end

        // R3: clear with write-one, write-zero leaves flags
        tag = "R3";
        flag_we = 1; flag_wdata = 8'h00; tick();
        check("R3", flag_rdata, 8'hC3, "write zero keeps flags");
        flag_wdata = 8'h01; tick();
        check("R3", flag_rdata[0], 1'b0, "rxf cleared");
        flag_wdata = 8'hC2; tick();
        check("R3", flag_rdata, 8'h00, "all cleared");
        idle(); tick();

        // R4: clear while condition still active
        tag = "R4";
        flag_evt = 4'b0010; tick();
        flag_we = 1; flag_wdata = 8'h02; tick();
        check("R4", flag_rdata[1], 1'b1, "clear ignored under condition");
        flag_evt = '0; tick();
        check("R4", flag_rdata[1], 1'b0, "cleared after condition drops");
        idle(); tick();

        // R5: status tracking, writes to status bits ignored
        tag = "R5";
        for (int k = 0; k < 16; k++) begin
            rx_lvl = 2'(k); tx_lvl = 2'(k >> 2);
            flag_we = 1; flag_wdata = 8'h3C;
            tick();
        end
        idle(); tick();

        // R9 / R10: enable register and irq
        tag = "R9";
        ien_we = 1; ien_wdata = 4'b1010; tick();
        ien_we = 0; tick();
        check("R9", ien_rdata, 4'b1010, "enable readback");
        tag = "R10";
        flag_evt = 4'b0001; tick();
        flag_evt = '0; tick();
        check("R10", irq, 1'b0, "disabled flag no irq");
        flag_evt = 4'b1000; tick();
        flag_evt = '0; tick();
        check("R10", irq, 1'b1, "enabled flag irq");
        flag_we = 1; flag_wdata = 8'h80; tick();
        check("R10", irq, 1'b0, "irq drops after clear");
        idle(); tick();

        // R8: partial handshake ignores writes, sets still apply
        tag = "R8";
        flag_evt = 4'b1111; tick();
        idle(); init_req = 1; tick();
        flag_we = 1; flag_wdata = 8'hFF; tick();
        check("R8", flag_rdata[7:6], 2'b11, "write ignored in request phase");
        idle(); flag_evt = 4'b0100; tick();
        idle();

        // R6 / R7: initialization mode
        tag = "R6";
        init_ack = 1; tick();
        tick();
        check("R6", {flag_rdata[7:6], flag_rdata[1:0]}, 4'b0000, "flags held zero");
        tag = "R7";
        for (int k = 0; k < 20; k++) begin
            flag_evt = 4'($urandom); rx_lvl = 2'($urandom); tx_lvl = 2'($urandom);
            tick();
        end
        idle(); tick();
        init_req = 0; flag_evt = 4'b0010; tick();
        idle(); flag_we = 1; flag_wdata = 8'h02; tick();
        check("R8", flag_rdata[1], 1'b1, "write ignored in exit phase");
        idle(); init_ack = 0; tick();
        flag_we = 1; flag_wdata = 8'h02; tick();
        idle(); tick();
        check("R8", flag_rdata[1], 1'b0, "write accepted after exit");

        // Mixed random traffic against the model
        tag = "R2";
        for (int k = 0; k < 3000; k++) begin
            flag_evt   = 4'($urandom) & 4'($urandom);
            rx_lvl     = 2'($urandom);
            tx_lvl     = 2'($urandom);
            flag_we    = 1'($urandom);
            flag_wdata = 8'($urandom);
            ien_we     = (($urandom % 8) == 0);
            ien_wdata  = 4'($urandom);
            if (($urandom % 50) == 0) begin
                init_req = ~init_req;
            end else if (($urandom % 50) == 0) begin
                init_ack = init_req;
            end
            tick();
        end

        // R11: reset again mid-run
        tag = "R11";
        idle(); rst = 1; tick(); tick();
        check("R11", {flag_rdata, ien_rdata}, 12'h000, "reset clears all");
        finish_run();
    end
endmodule